// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of a clocked serial master. It takes words from a transmit FIFO and shifts them out on MOSI. At the same time it samples MISO and pushes each assembled word into a receive FIFO. It generates SCK from the core clock through a programmable divider.

Static configuration inputs select the following:
- clock idle level and sampling phase;
- bit order;
- an 8-bit or 16-bit word;
- full-duplex operation or receive-only operation.

In receive-only operation the engine clocks words in without consuming transmit data. An enable input starts operation. A busy output reports that a word is in flight. A software reset input abandons the current word at once.

The engine works one word at a time. After the last SCK edge of a word it spends one idle cycle, in which it pushes the received word. If it is still enabled and has a word to send, it loads the next word in the following cycle. Chip select, slave operation and register access live outside this block.

Top module: `spi_shift_master`

## Requirements
- R1: After synchronous reset, sck is 0, busy is 0, and rx_push and tx_pop are 0.
- R2: Each SCK half-period lasts cfg_div core cycles, so the serial clock is the core clock divided by 2×cfg_div, with cfg_div a 14-bit value. The first SCK edge of a word comes cfg_div cycles after busy rises.
- R3: A cfg_div of 0 behaves exactly like a cfg_div of 1, so SCK toggles on every core cycle.
- R4: The SCK idle level is the inverse of cfg_cpol_n (1 gives idle low). SCK sits at that level whenever no word is in flight.
- R5: With cfg_cpha_n = 1, the first data bit is on MOSI from the cycle busy rises, MISO is sampled on the first edge of each SCK period, and MOSI changes on the second edge. With cfg_cpha_n = 0, MOSI changes on the first edge and MISO is sampled on the second. Both phase controls at 1 give SPI mode 0.
- R6: cfg_lsb_first = 1 sends and assembles bit 0 first. cfg_lsb_first = 0 sends and assembles the top bit of the word first.
- R7: cfg_wide = 1 gives 16-bit words. cfg_wide = 0 gives 8-bit words: tx_data[7:0] is sent and rx_data[15:8] reads 0.
- R8: With cfg_duplex = 1, a word starts only when tx_valid is high. In that cycle tx_pop pulses for one cycle and tx_data is taken. While the FIFO is empty the engine waits with busy low and SCK idle.
- R9: With cfg_duplex = 0, tx_pop never rises and MOSI is 0 during every word. Words follow each other for as long as the enable is held.
- R10: rx_push is a one-cycle pulse in the cycle after the last SCK edge of a word, with rx_data holding the word. busy is low in that cycle.
- R11: busy is high from the cycle after a word starts until the cycle after its last edge. Dropping cfg_enable mid-word does not cut the word short, and no further word starts while the enable is low.
- R12: cfg_soft_rst forces the engine idle in the next cycle: busy is low, SCK is at its idle level, and no rx_push is issued for the abandoned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Allows new words to start |
| cfg_soft_rst | input | 1 | Abandons the current word and holds the engine idle |
| cfg_div | input | 14 | SCK half-period in core cycles (0 treated as 1) |
| cfg_cpol_n | input | 1 | 1: SCK idles low, 0: SCK idles high |
| cfg_cpha_n | input | 1 | 1: sample on first edge, 0: sample on second edge |
| cfg_lsb_first | input | 1 | 1: bit 0 first, 0: top bit first |
| cfg_wide | input | 1 | 1: 16-bit words, 0: 8-bit words |
| cfg_duplex | input | 1 | 1: send and receive, 0: receive only |
| tx_data | input | 16 | Head of the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_pop | output | 1 | Takes tx_data this cycle |
| rx_data | output | 16 | Last received word |
| rx_push | output | 1 | Word-complete pulse that writes rx_data to the receive FIFO |
| busy | output | 1 | A word is being shifted |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The embedded properties take for granted that the configuration inputs hold still while busy is high, and that tx_data stays valid whenever tx_valid is high. The stimulus changes configuration only after the engine has drained and fallen idle, the one exception being the soft reset, which by definition does not wait. The transmit FIFO model in the bench presents data only while its queue is non-empty and drops the head only on the edge where a start was predicted. MISO changes only at falling core-clock edges, so every sample the engine takes is unambiguous.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SHIFT = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic cpol_n;
    logic cpha_n;
    logic lsb_first;
    logic wide;
    logic duplex;
  } frame_cfg_t;

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  // a programmed zero behaves as one: every cycle is an edge
  assign limit = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_shift_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic soft_rst,
  input  logic duplex,
  input  logic tx_valid,
  input  logic tick,
  input  logic last_edge,
  output logic start,
  output logic finish,
  output logic busy
);

  seq_state_e state;

  assign start  = (state == SEQ_IDLE) && en && !soft_rst && (!duplex || tx_valid);
  assign finish = (state == SEQ_SHIFT) && tick && last_edge;
  assign busy   = (state == SEQ_SHIFT);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) state <= SEQ_IDLE;
    else if (start)      state <= SEQ_SHIFT;
    else if (finish)     state <= SEQ_IDLE;
  end

  // R11: a word in flight is never dropped except by soft reset
  a_r11_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !finish && !soft_rst) |=> busy);

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path
  import spi_shift_pkg::*;
#(
  parameter int MAX_W   = 16,
  parameter int SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             start,
  input  logic             busy,
  input  logic             tick,
  input  logic             finish,
  input  frame_cfg_t       cfg,
  input  logic [MAX_W-1:0] tx_word,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             last_edge,
  output logic [MAX_W-1:0] rx_word,
  output logic             rx_push
);

  localparam int EW  = $clog2(2 * MAX_W);
  localparam int PAD = MAX_W - SHORT_W;

  logic [EW-1:0]      edge_cnt;
  logic               sck_q;
  logic [MAX_W-1:0]   ord_q;
  logic [MAX_W-1:0]   ord_load;
  logic [MAX_W-1:0]   rx_sr;
  logic [MAX_W-1:0]   rx_next;
  logic [MAX_W-1:0]   tx_rev_full;
  logic [MAX_W-1:0]   rx_rev_full;
  logic [SHORT_W-1:0] tx_rev_short;
  logic [SHORT_W-1:0] rx_rev_short;
  logic               capture;
  logic               advance;

  // bit reversal networks for the two word lengths
  generate
    for (genvar i = 0; i < MAX_W; i++) begin : g_rev_full
      assign tx_rev_full[i] = tx_word[MAX_W-1-i];
      assign rx_rev_full[i] = rx_next[MAX_W-1-i];
    end
    for (genvar j = 0; j < SHORT_W; j++) begin : g_rev_short
      assign tx_rev_short[j] = tx_word[SHORT_W-1-j];
      assign rx_rev_short[j] = rx_next[SHORT_W-1-j];
    end
  endgenerate

  // transmit word in send order, first bit at the top
  always_comb begin
    if (!cfg.duplex)   ord_load = '0;
    else if (cfg.wide) ord_load = cfg.lsb_first ? tx_rev_full : tx_word;
    else               ord_load = {(cfg.lsb_first ? tx_rev_short : tx_word[SHORT_W-1:0]),
                                   {PAD{1'b0}}};
  end

  // even edge count means the next edge is a leading one
  assign capture   = cfg.cpha_n ? ~edge_cnt[0] : edge_cnt[0];
  assign advance   = cfg.cpha_n ? edge_cnt[0] : (~edge_cnt[0] && (edge_cnt != '0));
  assign rx_next   = (tick && capture) ? {rx_sr[MAX_W-2:0], miso} : rx_sr;
  assign last_edge = (edge_cnt == (cfg.wide ? EW'(2*MAX_W-1) : EW'(2*SHORT_W-1)));
  assign mosi      = ord_q[MAX_W-1];
  assign sck       = sck_q;

  always_ff @(posedge clk) begin
    if (rst || clear || !busy) edge_cnt <= '0;
    else if (tick)             edge_cnt <= edge_cnt + EW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                 sck_q <= 1'b0;
    else if (clear || !busy) sck_q <= ~cfg.cpol_n;
    else if (tick)           sck_q <= ~sck_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                         ord_q <= '0;
    else if (start)                  ord_q <= ord_load;
    else if (busy && tick && advance) ord_q <= {ord_q[MAX_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst || start) rx_sr <= '0;
    else if (busy)    rx_sr <= rx_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word <= '0;
      rx_push <= 1'b0;
    end else begin
      rx_push <= finish && !clear;
      if (finish && !clear) begin
        if (cfg.wide) rx_word <= cfg.lsb_first ? rx_rev_full : rx_next;
        else          rx_word <= {{PAD{1'b0}},
                                  (cfg.lsb_first ? rx_rev_short : rx_next[SHORT_W-1:0])};
      end
    end
  end

  // R2: SCK moves only on divider edges while a word is in flight
  a_r2_sck_steady: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && !clear) |=> $stable(sck_q));

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_shift_pkg::*;
#(
  parameter int DIV_W   = 14,
  parameter int MAX_W   = 16,
  parameter int SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  logic             cfg_soft_rst,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cpol_n,
  input  logic             cfg_cpha_n,
  input  logic             cfg_lsb_first,
  input  logic             cfg_wide,
  input  logic             cfg_duplex,
  input  logic [MAX_W-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_pop,
  output logic [MAX_W-1:0] rx_data,
  output logic             rx_push,
  output logic             busy,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);

  frame_cfg_t cfg_s;
  logic       tick;
  logic       start;
  logic       finish;
  logic       last_edge;

  assign cfg_s.cpol_n    = cfg_cpol_n;
  assign cfg_s.cpha_n    = cfg_cpha_n;
  assign cfg_s.lsb_first = cfg_lsb_first;
  assign cfg_s.wide      = cfg_wide;
  assign cfg_s.duplex    = cfg_duplex;

  assign tx_pop = start && cfg_duplex;

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (cfg_div),
    .tick (tick)
  );

  spi_seq_ctrl u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_enable),
    .soft_rst  (cfg_soft_rst),
    .duplex    (cfg_duplex),
    .tx_valid  (tx_valid),
    .tick      (tick),
    .last_edge (last_edge),
    .start     (start),
    .finish    (finish),
    .busy      (busy)
  );

  spi_shift_path #(.MAX_W(MAX_W), .SHORT_W(SHORT_W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .clear     (cfg_soft_rst),
    .start     (start),
    .busy      (busy),
    .tick      (tick),
    .finish    (finish),
    .cfg       (cfg_s),
    .tx_word   (tx_data),
    .miso      (miso),
    .sck       (sck),
    .mosi      (mosi),
    .last_edge (last_edge),
    .rx_word   (rx_data),
    .rx_push   (rx_push)
  );

  // R8: a pop only ever takes a word that exists, and only in duplex mode
  a_r8_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> (tx_valid && cfg_duplex));

  // R9: receive-only words drive a quiet MOSI
  a_r9_rxonly_quiet: assert property (@(posedge clk) disable iff (rst)
    (busy && !cfg_duplex) |-> !mosi);

  // R10: the completion pulse comes once the shifting has ended
  a_r10_push_not_busy: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !busy);

  // R12: soft reset leaves the engine idle without a push
  a_r12_soft_clears: assert property (@(posedge clk) disable iff (rst)
    cfg_soft_rst |=> (!busy && !rx_push));

endmodule

// File: tb/sim_spi_shift_master.sv
module sim_spi_shift_master;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic        cfg_soft_rst = 1'b0;
  logic [13:0] cfg_div = 14'd1;
  logic        cfg_cpol_n = 1'b1;
  logic        cfg_cpha_n = 1'b1;
  logic        cfg_lsb_first = 1'b0;
  logic        cfg_wide = 1'b0;
  logic        cfg_duplex = 1'b1;
  logic [15:0] tx_data = 16'h0;
  logic        tx_valid = 1'b0;
  logic        tx_pop;
  logic [15:0] rx_data;
  logic        rx_push;
  logic        busy;
  logic        sck;
  logic        mosi;
  logic        miso = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [15:0] txq[$];
  logic [15:0] lfsr = 16'hACE1;

  // reference state
  int m_busy = 0, m_cnt = 0, m_e = 0, m_sck = 0, m_push = 0;
  int m_rxdata = 0, m_txw = 0, m_rxw = 0;
  int pops = 0, pushes = 0;

  spi_shift_master u0 (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_soft_rst(cfg_soft_rst),
    .cfg_div(cfg_div), .cfg_cpol_n(cfg_cpol_n), .cfg_cpha_n(cfg_cpha_n),
    .cfg_lsb_first(cfg_lsb_first), .cfg_wide(cfg_wide), .cfg_duplex(cfg_duplex),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_pop(tx_pop), .rx_data(rx_data),
    .rx_push(rx_push), .busy(busy), .sck(sck), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // serial slave data and FIFO head, both moved away from the rising edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso = lfsr[0];
    #1;
    tx_valid = (txq.size() != 0);
    tx_data  = (txq.size() != 0) ? txq[0] : 16'h0;
  end

  // behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    int n, d, cpol, cpha, idx, phys;
    n    = cfg_wide ? 16 : 8;
    d    = (cfg_div == 0) ? 1 : int'(cfg_div);
    cpol = cfg_cpol_n ? 0 : 1;
    cpha = cfg_cpha_n ? 0 : 1;
    m_push = 0;
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_e = 0; m_sck = 0;
    end else if (cfg_soft_rst) begin
      m_busy = 0; m_cnt = 0; m_e = 0; m_sck = cpol;
    end else if (m_busy == 0) begin
      m_sck = cpol; m_cnt = 0; m_e = 0;
      if (cfg_enable && (!cfg_duplex || tx_valid)) begin
        m_busy = 1;
        m_rxw  = 0;
        if (cfg_duplex) begin
          m_txw = int'(tx_data) & ((1 << n) - 1);
          void'(txq.pop_front());
          pops++;
        end else m_txw = 0;
      end
    end else if (m_cnt == d - 1) begin
      m_cnt = 0;
      if ((m_e % 2) == cpha) begin
        idx  = m_e / 2;
        phys = cfg_lsb_first ? idx : n - 1 - idx;
        if (miso) m_rxw = m_rxw | (1 << phys);
      end
      m_sck = 1 - m_sck;
      m_e++;
      if (m_e == 2 * n) begin
        m_busy = 0; m_push = 1; m_rxdata = m_rxw; m_e = 0;
      end
    end else begin
      m_cnt++;
    end
  end

  // per-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    int n, idx, phys, expbit, exppop;
    #(CLK_PERIOD/4);
    if (!rst && !done) begin
      n      = cfg_wide ? 16 : 8;
      exppop = (!m_busy && cfg_enable && !cfg_soft_rst && cfg_duplex && tx_valid) ? 1 : 0;
      check(sck == m_sck[0], "R2 sck", int'(sck), m_sck);
      check(busy == m_busy[0], "R11 busy", int'(busy), m_busy);
      check(rx_push == m_push[0], "R10 rx_push", int'(rx_push), m_push);
      check(tx_pop == exppop[0], "R8 tx_pop", int'(tx_pop), exppop);
      if (m_push != 0)
        check(int'(rx_data) == m_rxdata, "R7 rx_data", int'(rx_data), m_rxdata);
      if (m_busy != 0) begin
        if (!cfg_cpha_n) idx = (m_e == 0) ? 0 : (m_e - 1) / 2;
        else             idx = m_e / 2;
        phys   = cfg_lsb_first ? idx : n - 1 - idx;
        expbit = (m_txw >> phys) & 1;
        check(mosi == expbit[0], "R6 mosi", int'(mosi), expbit);
      end
      if (rx_push) pushes++;
    end
  end

  task automatic sample();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 60000; k++) begin
      @(negedge clk);
      if (txq.size() == 0 && m_busy == 0 && !busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_busy();
    for (int k = 0; k < 60000; k++) begin
      sample();
      if (busy) break;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int p0, q0, toggles;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sample();
    check(sck == 1'b0, "R1 sck after reset", int'(sck), 0);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(rx_push == 1'b0 && tx_pop == 1'b0, "R1 pulses after reset",
          int'({rx_push, tx_pop}), 0);

    // mode 0, 8-bit, top bit first, duplex
    @(negedge clk);
    cfg_div = 14'd2; cfg_wide = 0; cfg_lsb_first = 0; cfg_duplex = 1;
    cfg_cpol_n = 1; cfg_cpha_n = 1;
    p0 = pushes;
    txq.push_back(16'h00A5); txq.push_back(16'h003C); txq.push_back(16'hFF01);
    repeat (2) @(negedge clk);
    cfg_enable = 1;
    wait_busy();
    check(mosi == 1'b1, "R5 first bit before first edge", int'(mosi), 1);
    wait_drain();
    cfg_enable = 0;
    check(pushes - p0 == 3, "R8 one word per queued entry", pushes - p0, 3);

    // mode 3, 16-bit, bit 0 first
    @(negedge clk);
    cfg_div = 14'd3; cfg_wide = 1; cfg_lsb_first = 1; cfg_cpol_n = 0; cfg_cpha_n = 0;
    txq.push_back(16'hBEEF); txq.push_back(16'h1234);
    repeat (3) @(negedge clk);
    cfg_enable = 1;
    wait_drain();
    cfg_enable = 0;

    // mode 1 16-bit top first, then mode 2 8-bit bit 0 first
    @(negedge clk);
    cfg_div = 14'd1; cfg_lsb_first = 0; cfg_cpol_n = 1; cfg_cpha_n = 0;
    txq.push_back(16'h8001);
    cfg_enable = 1;
    wait_drain();
    cfg_enable = 0;
    @(negedge clk);
    cfg_div = 14'd5; cfg_wide = 0; cfg_lsb_first = 1; cfg_cpol_n = 0; cfg_cpha_n = 1;
    txq.push_back(16'h0096); txq.push_back(16'h0071);
    cfg_enable = 1;
    wait_drain();
    cfg_enable = 0;
    repeat (2) sample();
    check(sck == 1'b1, "R4 idle high with cfg_cpol_n=0", int'(sck), 1);

    // empty FIFO stall in duplex mode
    @(negedge clk);
    cfg_cpol_n = 1;
    cfg_enable = 1;
    repeat (30) sample();
    check(busy == 1'b0, "R8 stall keeps busy low", int'(busy), 0);
    check(sck == 1'b0, "R8 stall keeps sck idle", int'(sck), 0);
    check(tx_pop == 1'b0, "R8 no pop when empty", int'(tx_pop), 0);
    @(negedge clk);
    txq.push_back(16'h005A);
    wait_drain();
    cfg_enable = 0;

    // receive-only, divider 0
    @(negedge clk);
    cfg_duplex = 0; cfg_div = 14'd0; cfg_wide = 1; cfg_lsb_first = 0; cfg_cpha_n = 1;
    q0 = pops; p0 = pushes;
    repeat (2) @(negedge clk);
    cfg_enable = 1;
    wait_busy();
    prev = sck; toggles = 0;
    for (int k = 0; k < 10; k++) begin
      sample();
      if (sck != prev) toggles++;
      prev = sck;
    end
    check(toggles == 10, "R3 divider 0 toggles every cycle", toggles, 10);
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (pushes - p0 >= 3) break;
    end
    repeat (5) @(negedge clk);
    cfg_enable = 0;
    p0 = pushes;
    sample();
    check(busy == 1'b1, "R11 busy held after enable drop", int'(busy), 1);
    wait_drain();
    check(pushes - p0 == 1, "R11 word finished after enable drop", pushes - p0, 1);
    repeat (40) sample();
    check(busy == 1'b0, "R11 no new word while disabled", int'(busy), 0);
    check(pops == q0, "R9 receive-only pops nothing", pops - q0, 0);

    // soft reset mid-word
    @(negedge clk);
    cfg_duplex = 1; cfg_div = 14'd4; cfg_wide = 0;
    txq.push_back(16'h00C3);
    cfg_enable = 1;
    repeat (20) @(negedge clk);
    p0 = pushes;
    cfg_soft_rst = 1; cfg_enable = 0;
    sample();
    check(busy == 1'b0, "R12 busy cleared", int'(busy), 0);
    check(sck == 1'b0, "R12 sck idle", int'(sck), 0);
    @(negedge clk);
    cfg_soft_rst = 0;
    repeat (100) @(negedge clk);
    check(pushes == p0, "R12 no push for abandoned word", pushes - p0, 0);

    // wide divider: half-period measurement
    @(negedge clk);
    cfg_div = 14'd1000;
    txq.push_back(16'h0011);
    cfg_enable = 1;
    wait_busy();
    toggles = 0;
    prev = sck;
    for (int k = 0; k < 1100; k++) begin
      sample();
      toggles++;
      if (sck != prev) break;
    end
    check(toggles == 1000, "R2 half period equals divider", toggles, 1000);
    wait_drain();
    cfg_enable = 0;
    repeat (5) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule